// File: doc/BRIEF.md
# Line-Locked Sample Fetcher with Pulse-Width Output

This block reads one audio sample per horizontal video line from a buffer in shared RAM and turns it into a pulse-width-modulated output bit. The memory arbiter grants the block one bus slot at the end of each line. In that slot the block places a word address on the bus and captures one byte lane of the returned 16-bit word. The captured byte waits in a holding register. It becomes the duty value at the next line start, so every PWM period runs a full line and is never cut short. The sample rate is therefore tied to the line rate, and one frame uses as many samples as it has line periods.

A read offset steps through the buffer once per fetch. The offset goes back to zero at the vertical-retrace pulse. If no retrace pulse arrives, it also wraps after a full frame's worth of lines. One select input chooses between two buffer base addresses. A 3-bit volume code scales the duty in eight steps, from 1/8 of the sample up to the full sample, which spans about 18 dB. A parameter removes the volume stage. With it removed, the same engine drives a motor-speed PWM straight from the table values.

The PWM period is one line, so `LINE_CLKS` must be at least 256. This lets a full-scale duty of 255 fit within a single line.

Top module: `line_sound_dma`

## Requirements
- R1: While reset is held, and right after it, `pwmOut` is 0, `memRd` is 0 and `memAddr` equals `MAIN_BASE`, because the read offset is 0.
- R2: `memRd` is 1 in exactly the cycles where `slotGrant` is 1. The sample is byte `memRdata[15:8]` when `SAMPLE_HI`=1, and byte `memRdata[7:0]` when `SAMPLE_HI`=0.
- R3: Each grant advances the read offset by one. The offset after offset `LINES_PER_FRAME`-1 is 0.
- R4: A `frameStart` pulse sets the offset to 0. If `frameStart` and `slotGrant` fall in the same cycle, the fetch uses the old offset and the offset still becomes 0.
- R5: During a grant, `memAddr` = base + offset, where the base is `MAIN_BASE` when `bufSel`=0 and `ALT_BASE` when `bufSel`=1. `bufSel` is read in the grant cycle.
- R6: A fetched sample has no effect on `pwmOut` until the next `lineStart`. At that edge the PWM count restarts from 0.
- R7: After a `lineStart` edge, `pwmOut` is 1 for the first D clocks and 0 for the rest of the line, where D is the duty loaded at that edge.
- R8: With scaling on, D = (sample × (volume+1)) >> 3, using the volume sampled at `lineStart`. A volume change in the middle of a line does not change that line's pulse.
- R9: In a line without a grant, the sample held from the last fetch is used again.
- R10: With `SCALE_EN`=0, D equals the raw sample and the volume input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lineStart | input | 1 | One-cycle pulse at the start of each horizontal line |
| frameStart | input | 1 | One-cycle vertical-retrace pulse; sets the read offset to 0 |
| slotGrant | input | 1 | Arbiter grant of the last bus slot of the line |
| bufSel | input | 1 | Buffer select: 0 = main buffer, 1 = alternate buffer |
| volume | input | 3 | Volume code; 7 = full scale, 0 = one eighth |
| memRdata | input | 16 | Word read from RAM, valid in the grant cycle |
| memRd | output | 1 | Read strobe for the granted slot |
| memAddr | output | ADDR_W | Word address of the current sample |
| pwmOut | output | 1 | Pulse-width-modulated output bit |

## Verification
The bench builds the block with `LINES_PER_FRAME`=6 and `LINE_CLKS`=260, with the buffer bases at 0x1000 and 0x2000. With these values the offset wraps within a few lines, and a full-scale duty of 255 still fits inside one line. A second instance built with `SCALE_EN`=0 runs beside the first on the same stimulus. This lets the motor-table variant be compared against the volume-scaled one line by line.

// File: rtl/line_snd_pkg.sv
package line_snd_pkg;

  // Strobes passed from the fetch control to the PWM datapath
  typedef struct packed {
    logic fetch;     // capture the sample byte this cycle
    logic loadLine;  // line boundary: apply the held sample, restart the count
    logic rewind;    // vertical retrace seen
  } sndStrobe_t;

endpackage

// File: rtl/snd_fetch_ctrl.sv
module snd_fetch_ctrl
  import line_snd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LINES_PER_FRAME = 370,
  parameter int PTR_W = 9,
  parameter logic [ADDR_W-1:0] MAIN_BASE = '0,
  parameter logic [ADDR_W-1:0] ALT_BASE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineStart,
  input  logic              frameStart,
  input  logic              slotGrant,
  input  logic              bufSel,
  output sndStrobe_t        strobes,
  output logic              memRd,
  output logic [ADDR_W-1:0] memAddr,
  output logic [PTR_W-1:0]  rdPtr
);

  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(LINES_PER_FRAME - 1);

  logic [ADDR_W-1:0] baseAddr;

  always_comb begin
    strobes.fetch    = slotGrant;
    strobes.loadLine = lineStart;
    strobes.rewind   = frameStart;
  end

  assign baseAddr = bufSel ? ALT_BASE : MAIN_BASE;
  assign memAddr  = baseAddr + ADDR_W'(rdPtr);
  assign memRd    = slotGrant;

  // The retrace pulse has priority over the step; a fetch in the same
  // cycle has already used the old offset on the combinational address.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
    end else if (frameStart) begin
      rdPtr <= '0;
    end else if (slotGrant) begin
      rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
    end
  end

endmodule

// File: rtl/snd_vol_scale.sv
module snd_vol_scale #(
  parameter int SAMPLE_W = 8,
  parameter int VOL_W = 3
) (
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [VOL_W-1:0]    volume,
  output logic [SAMPLE_W-1:0] scaled
);

  localparam int PROD_W = SAMPLE_W + VOL_W;

  logic [PROD_W-1:0] product;

  // Gain is (volume+1)/2^VOL_W, so the top code passes the sample unchanged
  assign product = PROD_W'(sample) * (PROD_W'(volume) + PROD_W'(1));
  assign scaled  = product[PROD_W-1:VOL_W];

endmodule

// File: rtl/snd_pwm_path.sv
module snd_pwm_path
  import line_snd_pkg::*;
#(
  parameter int SAMPLE_HI = 1,
  parameter int SCALE_EN = 1,
  parameter int LINE_CLKS = 352,
  parameter int CNT_W = 9
) (
  input  logic        clk,
  input  logic        rstN,
  input  sndStrobe_t  strobes,
  input  logic [15:0] memRdata,
  input  logic [2:0]  volume,
  output logic [7:0]  activeDuty,
  output logic        pwmOut
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LINE_CLKS);

  logic [7:0]       laneByte;
  logic [7:0]       heldSample;
  logic [7:0]       scaledDuty;
  logic [CNT_W-1:0] lineCnt;

  generate
    if (SAMPLE_HI != 0) begin : g_hiLane
      assign laneByte = memRdata[15:8];
    end else begin : g_loLane
      assign laneByte = memRdata[7:0];
    end
  endgenerate

  generate
    if (SCALE_EN != 0) begin : g_scaled
      snd_vol_scale #(.SAMPLE_W(8), .VOL_W(3)) u_scale (
        .sample (heldSample),
        .volume (volume),
        .scaled (scaledDuty)
      );
    end else begin : g_raw
      logic unusedVolume;
      assign unusedVolume = ^volume;
      assign scaledDuty   = heldSample;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldSample <= '0;
    end else if (strobes.fetch) begin
      heldSample <= laneByte;
    end
  end

  // Duty and count change only at a line boundary, so a period is never cut
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeDuty <= '0;
      lineCnt    <= CNT_MAX;
    end else if (strobes.loadLine) begin
      activeDuty <= scaledDuty;
      lineCnt    <= '0;
    end else if (lineCnt != CNT_MAX) begin
      lineCnt <= lineCnt + 1'b1;
    end
  end

  assign pwmOut = ({{(CNT_W-8){1'b0}}, activeDuty} > lineCnt);

endmodule

// File: rtl/line_sound_dma.sv
module line_sound_dma
  import line_snd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LINES_PER_FRAME = 370,
  parameter int LINE_CLKS = 352,
  parameter logic [ADDR_W-1:0] MAIN_BASE = 16'h7D00,
  parameter logic [ADDR_W-1:0] ALT_BASE = 16'h7A00,
  parameter int SAMPLE_HI = 1,
  parameter int SCALE_EN = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineStart,
  input  logic              frameStart,
  input  logic              slotGrant,
  input  logic              bufSel,
  input  logic [2:0]        volume,
  input  logic [15:0]       memRdata,
  output logic              memRd,
  output logic [ADDR_W-1:0] memAddr,
  output logic              pwmOut
);

  localparam int PTR_W = (LINES_PER_FRAME > 1) ? $clog2(LINES_PER_FRAME) : 1;
  localparam int CNT_W = $clog2(LINE_CLKS + 1);

  sndStrobe_t       strobes;
  logic [PTR_W-1:0] rdPtr;
  logic [7:0]       activeDuty;

  snd_fetch_ctrl #(
    .ADDR_W(ADDR_W), .LINES_PER_FRAME(LINES_PER_FRAME), .PTR_W(PTR_W),
    .MAIN_BASE(MAIN_BASE), .ALT_BASE(ALT_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .frameStart(frameStart),
    .slotGrant(slotGrant), .bufSel(bufSel), .strobes(strobes),
    .memRd(memRd), .memAddr(memAddr), .rdPtr(rdPtr)
  );

  snd_pwm_path #(
    .SAMPLE_HI(SAMPLE_HI), .SCALE_EN(SCALE_EN),
    .LINE_CLKS(LINE_CLKS), .CNT_W(CNT_W)
  ) u_path (
    .clk(clk), .rstN(rstN), .strobes(strobes), .memRdata(memRdata),
    .volume(volume), .activeDuty(activeDuty), .pwmOut(pwmOut)
  );

endmodule

// File: rtl/snd_dma_chk.sv
module snd_dma_chk #(
  parameter int PTR_W = 9,
  parameter int LINES_PER_FRAME = 370
) (
  input logic             clk,
  input logic             rstN,
  input logic             lineStart,
  input logic             frameStart,
  input logic             slotGrant,
  input logic             pwmOut,
  input logic [PTR_W-1:0] rdPtr,
  input logic [7:0]       activeDuty
);

  // R4
  rewind_to_base_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> (rdPtr == '0));

  // R3
  ptr_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(rdPtr) < LINES_PER_FRAME);

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slotGrant && !frameStart) |=>
      (int'(rdPtr) == (int'($past(rdPtr)) + 1) % LINES_PER_FRAME));

  // R9
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!slotGrant && !frameStart) |=> $stable(rdPtr));

  // R6
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lineStart |=> $stable(activeDuty));

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!lineStart && !pwmOut) |=> !pwmOut);

endmodule

bind line_sound_dma snd_dma_chk #(
  .PTR_W(PTR_W), .LINES_PER_FRAME(LINES_PER_FRAME)
) u_chk (
  .clk(clk), .rstN(rstN), .lineStart(lineStart), .frameStart(frameStart),
  .slotGrant(slotGrant), .pwmOut(pwmOut), .rdPtr(rdPtr), .activeDuty(activeDuty)
);

// File: tb/tb_line_sound_dma.sv
`timescale 1ns/1ps
module tb_line_sound_dma;

  localparam int LPF = 6;
  localparam int LC = 260;
  localparam logic [15:0] MB = 16'h1000;
  localparam logic [15:0] AB = 16'h2000;

  typedef struct packed {
    logic [15:0] word;
    logic [2:0]  vol;
    logic        sel;
    logic        frame;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{16'hC837, 3'd7, 1'b0, 1'b1},
    '{16'h4012, 3'd7, 1'b0, 1'b0},
    '{16'hFF00, 3'd3, 1'b1, 1'b0},
    '{16'h0155, 3'd0, 1'b1, 1'b0},
    '{16'h80AA, 3'd5, 1'b0, 1'b0},
    '{16'h00FF, 3'd7, 1'b1, 1'b0},
    '{16'h7F7F, 3'd2, 1'b0, 1'b1},
    '{16'h2000, 3'd6, 1'b1, 1'b0},
    '{16'hE0E0, 3'd1, 1'b0, 1'b0},
    '{16'h10FF, 3'd4, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineStart = 1'b0, frameStart = 1'b0, slotGrant = 1'b0, bufSel = 1'b0;
  logic [2:0] volume = 3'd7;
  logic [15:0] memRdata = '0;
  logic memRd, memRdM, pwmOut, pwmOutM;
  logic [15:0] memAddr, memAddrM;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [7:0] heldM = '0;
  int ptrM = 0;

  always #2 clk = ~clk;

  line_sound_dma #(.ADDR_W(16), .LINES_PER_FRAME(LPF), .LINE_CLKS(LC),
    .MAIN_BASE(MB), .ALT_BASE(AB), .SAMPLE_HI(1), .SCALE_EN(1)) dut (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .frameStart(frameStart),
    .slotGrant(slotGrant), .bufSel(bufSel), .volume(volume), .memRdata(memRdata),
    .memRd(memRd), .memAddr(memAddr), .pwmOut(pwmOut));

  line_sound_dma #(.ADDR_W(16), .LINES_PER_FRAME(LPF), .LINE_CLKS(LC),
    .MAIN_BASE(MB), .ALT_BASE(AB), .SAMPLE_HI(1), .SCALE_EN(0)) dutMotor (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .frameStart(frameStart),
    .slotGrant(slotGrant), .bufSel(bufSel), .volume(volume), .memRdata(memRdata),
    .memRd(memRdM), .memAddr(memAddrM), .pwmOut(pwmOutM));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic int scaleOf(input logic [7:0] s, input logic [2:0] v);
    return (int'(s) * (int'(v) + 1)) / 8;
  endfunction

  // One line: lineStart at k=0, grant at k=LC-1; frameAt = -1 for none
  task automatic doLine(input logic [15:0] word, input bit grant, input int frameAt,
                        input logic [2:0] vol, input logic [2:0] midVol,
                        input bit sel, input string tag);
    int hi = 0, hiM = 0;
    logic [15:0] addrSeen = '0;
    bit rdSeen = 0;
    int expHi, expHiM, expAddr;
    expHi  = scaleOf(heldM, vol);
    expHiM = int'(heldM);
    if (frameAt == 0) ptrM = 0;
    expAddr = int'(sel ? AB : MB) + ptrM;
    for (int k = 0; k < LC; k++) begin
      @(negedge clk);
      if (k > 0) begin
        hi  += int'(pwmOut);
        hiM += int'(pwmOutM);
      end
      lineStart  = (k == 0);
      frameStart = (k == frameAt);
      slotGrant  = grant && (k == LC - 1);
      bufSel     = sel;
      memRdata   = (k == LC - 1) ? word : 16'hDEAD;
      if (k == 0) volume = vol;
      if (k == LC / 2) volume = midVol;
      #1;
      if (k == LC - 1) begin
        addrSeen = memAddr;
        rdSeen   = memRd;
      end
    end
    @(negedge clk);
    hi  += int'(pwmOut);
    hiM += int'(pwmOutM);
    lineStart = 0; frameStart = 0; slotGrant = 0;
    check(hi == expHi, {tag, " R6 R7 pulse width"}, hi, expHi);
    check(hiM == expHiM, {tag, " R10 motor width"}, hiM, expHiM);
    check(rdSeen == grant, {tag, " R2 read strobe"}, int'(rdSeen), int'(grant));
    if (grant) begin
      check(int'(addrSeen) == expAddr, {tag, " R5 R3 address"}, int'(addrSeen), expAddr);
      heldM = word[15:8];
      if (frameAt == LC - 1) ptrM = 0;
      else ptrM = (ptrM + 1) % LPF;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(pwmOut == 1'b0, "R1 pwm in reset", int'(pwmOut), 0);
    check(memRd == 1'b0, "R1 read in reset", int'(memRd), 0);
    check(memAddr == MB, "R1 address in reset", int'(memAddr), int'(MB));
    rstN = 1'b1;
    @(negedge clk);
    check(pwmOut == 1'b0, "R1 pwm after reset", int'(pwmOut), 0);

    // Table walk: R2 R5 R6 R7 R8 R10
    foreach (VECS[i]) begin
      doLine(VECS[i].word, 1'b1, VECS[i].frame ? 0 : -1, VECS[i].vol,
             VECS[i].vol, VECS[i].sel, "R8 table");
    end

    // R3: offset wrap after LPF fetches without a retrace
    doLine(16'h3300, 1'b1, 0, 3'd7, 3'd7, 1'b0, "R3 wrap");
    for (int n = 0; n < LPF + 1; n++)
      doLine(16'h5000 + 16'(n << 8), 1'b1, -1, 3'd7, 3'd7, 1'b0, "R3 wrap");

    // R4: retrace coincident with grant; fetch uses old offset, next uses 0
    doLine(16'h6100, 1'b1, LC - 1, 3'd7, 3'd7, 1'b1, "R4 coincident");
    doLine(16'h6200, 1'b1, -1, 3'd7, 3'd7, 1'b1, "R4 after rewind");

    // R9: line without grant reuses held sample, twice
    doLine(16'hAB00, 1'b0, -1, 3'd7, 3'd7, 1'b0, "R9 no grant");
    doLine(16'hAC00, 1'b0, -1, 3'd7, 3'd7, 1'b0, "R9 still held");
    doLine(16'hFF00, 1'b1, -1, 3'd7, 3'd7, 1'b0, "R9 resume");

    // R8: full scale, then volume dropped mid-line must not alter the pulse
    doLine(16'h0000, 1'b1, -1, 3'd7, 3'd0, 1'b0, "R8 midline volume");
    // R7: zero sample gives no pulse
    doLine(16'h9000, 1'b1, -1, 3'd0, 3'd7, 1'b0, "R7 zero duty");
    doLine(16'h0000, 1'b1, -1, 3'd0, 3'd0, 1'b0, "R8 lowest volume");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule